// File: doc/BRIEF.md
# Power Threshold Monitor Register Block

This block watches a measured power figure, in whole watts, against two thresholds that software sets. Each threshold has its own alarm flag, and together the flags set a throttle request level for the throttling logic: the lower step asks for half throttling and the upper step asks for heavy (90%) throttling. The block also holds two read-only power-limit words, one for the host processor and one for the FPGA fabric. Each limit word carries an enable flag, and its value reads as zero while that flag is clear. A latency-tolerance flag sits in the same status word as the consumption figure.

Software uses a 64-bit read/write register port. Reads are combinational on the address. Writes take effect at the clock edge where the write strobe is high. To change one threshold, software reads the threshold word, edits the field it wants and writes the whole word back, so the other field keeps its value. The power sample, the latency flag and the two raw limits all come in on ports. The alarm flags and the throttle level are registered, and they move one clock after the change to the consumption or threshold register that causes them.

Top module: `pwr_guard_regs`

## Requirements
- R1: After reset, both thresholds read 0x7F, the latched consumption reads 0, both alarm flags read 0 and `throttle_lvl` is 0.
- R2: A read at offset 0x08 returns the latched consumption in bits 17:0 and the latency-tolerance flag in bit 18. All other bits read 0. The flag follows `lat_ok_in` one clock later: 1 means every accelerator unit tolerates at least 40 us of memory latency, 0 means some unit is latency sensitive.
- R3: A write at offset 0x10 loads threshold A from bits 6:0 and threshold B from bits 14:8, both in watts and so at most 127. Every other write bit is ignored. A read at 0x10 returns the two thresholds at those same positions.
- R4: Bit 16 of the word at 0x10, and `alarm_lo`, are 1 while the consumption is at or above threshold A. Bit 17, and `alarm_hi`, are 1 while the consumption is at or above threshold B.
- R5: `throttle_lvl` is 2 (90% throttling) while `alarm_hi` is set, 1 (50% throttling) while only `alarm_lo` is set, and 0 otherwise. Level 3 never occurs. The level and the alarms change one clock after the consumption or threshold register changes.
- R6: Offsets 0x18 (host limit) and 0x20 (FPGA limit) return the enable flag in bit 15. Bits 14:0 carry the limit in units of 0.1 W when the flag is set and read 0 when it is clear. Both words follow their input ports one clock later.
- R7: Writes to 0x08, 0x18, 0x20 and to unmapped offsets change no state.
- R8: A read at any unmapped offset returns 0.
- R9: The consumption is latched only in a cycle where `pwr_vld` is high, and it holds its value between samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for `bus_addr` (combinational) |
| pwr_in | input | 18 | Measured power in watts |
| pwr_vld | input | 1 | `pwr_in` holds a new sample |
| lat_ok_in | input | 1 | All accelerator units tolerate at least 40 us of latency |
| host_lim_in | input | 15 | Host processor power limit, 0.1 W units |
| host_lim_en | input | 1 | Host limit is valid |
| fpga_lim_in | input | 15 | FPGA power limit, 0.1 W units |
| fpga_lim_en | input | 1 | FPGA limit is valid |
| alarm_lo | output | 1 | Consumption is at or above threshold A |
| alarm_hi | output | 1 | Consumption is at or above threshold B |
| throttle_lvl | output | 2 | Throttle request: 0 none, 1 half, 2 heavy |

## Verification
The hardest state to reach from the ports is an inverted threshold pair. When threshold B is below threshold A, the consumption can sit between them, so `alarm_hi` is set while `alarm_lo` is clear, and the level must still be 2. Random threshold values are drawn from a narrow range around the random samples, so this ordering and exact equality with a threshold both come up often. Directed steps add a zero threshold, a full-scale sample, a threshold write with junk in its unused bits, and a one-clock check that the level has not yet moved in the clock where a sample lands.

// File: rtl/pwr_guard_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the power threshold monitor.
// Assumes byte offsets on the register port and a 64-bit data word.
package pwr_guard_pkg;

    localparam int DATA_W   = 64;
    localparam int ADDR_W   = 8;
    localparam int PWR_W    = 18;
    localparam int TH_W     = 7;
    localparam int LIM_W    = 15;
    localparam int N_THR    = 2;

    // Register offsets
    localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_THRESH = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_HOST   = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_FPGA   = 8'h20;

    // Field positions inside the threshold word
    localparam int THA_LSB   = 0;
    localparam int THB_LSB   = 8;
    localparam int ALA_BIT   = 16;
    localparam int ALB_BIT   = 17;

    // Threshold value loaded at reset (full scale)
    localparam logic [TH_W-1:0] TH_RESET = '1;

    // Throttle request encoding
    typedef enum logic [1:0] {
        THR_NONE  = 2'd0,
        THR_HALF  = 2'd1,
        THR_HEAVY = 2'd2
    } throttle_e;

endpackage

// File: rtl/pwr_thr_store.sv
`timescale 1ns/1ps
// Holds the two software-written thresholds.
// Assumes the caller decodes the address; a write loads both fields at once,
// so software keeps one field by writing back the value it read.
module pwr_thr_store #(
    parameter int DATA_W = 64,
    parameter int TH_W   = 7,
    parameter int N_THR  = 2,
    parameter int FIELD_STRIDE = 8,
    parameter logic [TH_W-1:0] TH_RESET = '1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [DATA_W-1:0]           wdata,
    output logic [N_THR-1:0][TH_W-1:0]  th_q
);

    generate
        for (genvar g = 0; g < N_THR; g++) begin : g_field
            localparam int LSB = g * FIELD_STRIDE;
            // Load one threshold field from its slice of the write word
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    th_q[g] <= TH_RESET;
                end else if (wr_en) begin
                    th_q[g] <= wdata[LSB +: TH_W];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/pwr_alarm_cmp.sv
`timescale 1ns/1ps
// Compares the latched consumption with each threshold and registers the
// alarms plus the encoded throttle level. The highest alarm that is set
// picks the level. Assumes thresholds are unsigned whole watts.
module pwr_alarm_cmp
    import pwr_guard_pkg::*;
#(
    parameter int PWR_W = 18,
    parameter int TH_W  = 7,
    parameter int N_THR = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [PWR_W-1:0]            cons,
    input  logic [N_THR-1:0][TH_W-1:0]  th,
    output logic [N_THR-1:0]            alarm_q,
    output logic [1:0]                  level_q
);

    logic [N_THR-1:0] alarm_d;
    logic [1:0]       level_d;

    generate
        for (genvar g = 0; g < N_THR; g++) begin : g_cmp
            // Threshold reached when consumption is equal or greater
            always_comb alarm_d[g] = (cons >= PWR_W'(th[g]));
        end
    endgenerate

    // Priority encode: the upper step wins over the lower step
    always_comb begin
        level_d = THR_NONE;
        for (int i = 0; i < N_THR; i++) begin
            if (alarm_d[i]) level_d = 2'(i + 1);
        end
    end

    // Register alarms and level together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= '0;
            level_q <= THR_NONE;
        end else begin
            alarm_q <= alarm_d;
            level_q <= level_d;
        end
    end

endmodule

// File: rtl/pwr_limit_cap.sv
`timescale 1ns/1ps
// Captures one externally supplied power limit with its valid flag.
// The stored value is forced to zero while the flag is clear.
module pwr_limit_cap #(
    parameter int LIM_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LIM_W-1:0] lim_in,
    input  logic             lim_en,
    output logic [LIM_W:0]   word_q
);

    // Register the flag on top and the gated value below it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= {lim_en, (lim_en ? lim_in : {LIM_W{1'b0}})};
        end
    end

endmodule

// File: rtl/pwr_guard_regs.sv
`timescale 1ns/1ps
// Power threshold monitor register block (top).
// Latches power samples, holds two thresholds, raises alarms and a throttle
// request, and shows two read-only limit words. Reads are combinational on
// bus_addr; writes land on the clock edge where bus_wr is high.
module pwr_guard_regs
    import pwr_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PWR_W-1:0]  pwr_in,
    input  logic              pwr_vld,
    input  logic              lat_ok_in,
    input  logic [LIM_W-1:0]  host_lim_in,
    input  logic              host_lim_en,
    input  logic [LIM_W-1:0]  fpga_lim_in,
    input  logic              fpga_lim_en,
    output logic              alarm_lo,
    output logic              alarm_hi,
    output logic [1:0]        throttle_lvl
);

    localparam int N_LIM = 2;
    localparam int STRIDE = THB_LSB - THA_LSB;

    logic [PWR_W-1:0]             cons_q;
    logic                         lat_q;
    logic [N_THR-1:0][TH_W-1:0]   th_q;
    logic [N_THR-1:0]             alarm_q;
    logic [1:0]                   level_q;
    logic [N_LIM-1:0][LIM_W:0]    lim_word;
    logic [N_LIM-1:0][LIM_W-1:0]  lim_raw;
    logic [N_LIM-1:0]             lim_en;
    logic                         thr_wr;

    // Latch a power sample only when it is flagged valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cons_q <= '0;
        end else if (pwr_vld) begin
            cons_q <= pwr_in;
        end
    end

    // Register the latency-tolerance flag every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= 1'b0;
        else        lat_q <= lat_ok_in;
    end

    // Only the threshold word is writable
    always_comb thr_wr = bus_wr && (bus_addr == OFF_THRESH);

    pwr_thr_store #(
        .DATA_W       (DATA_W),
        .TH_W         (TH_W),
        .N_THR        (N_THR),
        .FIELD_STRIDE (STRIDE),
        .TH_RESET     (TH_RESET)
    ) u_thr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (thr_wr),
        .wdata (bus_wdata),
        .th_q  (th_q)
    );

    pwr_alarm_cmp #(
        .PWR_W (PWR_W),
        .TH_W  (TH_W),
        .N_THR (N_THR)
    ) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .cons    (cons_q),
        .th      (th_q),
        .alarm_q (alarm_q),
        .level_q (level_q)
    );

    // Gather limit inputs into arrays: index 0 host, index 1 FPGA
    always_comb begin
        lim_raw[0] = host_lim_in;
        lim_en[0]  = host_lim_en;
        lim_raw[1] = fpga_lim_in;
        lim_en[1]  = fpga_lim_en;
    end

    generate
        for (genvar g = 0; g < N_LIM; g++) begin : g_lim
            pwr_limit_cap #(.LIM_W(LIM_W)) u_lim (
                .clk    (clk),
                .rst_n  (rst_n),
                .lim_in (lim_raw[g]),
                .lim_en (lim_en[g]),
                .word_q (lim_word[g])
            );
        end
    endgenerate

    // Read multiplexer; unmapped offsets return zero
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFF_STATUS: begin
                bus_rdata[PWR_W-1:0] = cons_q;
                bus_rdata[PWR_W]     = lat_q;
            end
            OFF_THRESH: begin
                bus_rdata[THA_LSB +: TH_W] = th_q[0];
                bus_rdata[THB_LSB +: TH_W] = th_q[1];
                bus_rdata[ALA_BIT]         = alarm_q[0];
                bus_rdata[ALB_BIT]         = alarm_q[1];
            end
            OFF_HOST: bus_rdata[LIM_W:0] = lim_word[0];
            OFF_FPGA: bus_rdata[LIM_W:0] = lim_word[1];
            default:  bus_rdata = '0;
        endcase
    end

    // Drive the alarm and throttle outputs
    always_comb begin
        alarm_lo     = alarm_q[0];
        alarm_hi     = alarm_q[1];
        throttle_lvl = level_q;
    end

endmodule

// File: rtl/pwr_guard_regs_chk.sv
`timescale 1ns/1ps
// Property checker for pwr_guard_regs, attached with bind below.
module pwr_guard_regs_chk
    import pwr_guard_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              pwr_vld,
    input logic [PWR_W-1:0]  cons_q,
    input logic [TH_W-1:0]   th_a,
    input logic              alarm_lo,
    input logic              alarm_hi,
    input logic [1:0]        throttle_lvl
);

    // R5
    lvl_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        throttle_lvl != 2'd3);

    // R5
    lvl_heavy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (throttle_lvl == 2'd2) == alarm_hi);

    // R4
    alarm_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_lo == ($past(cons_q) >= PWR_W'($past(th_a))));

    // R7
    ro_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_STATUS && !pwr_vld) |=> $stable(cons_q));

    // R6
    lim_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr == OFF_HOST || bus_addr == OFF_FPGA) && !bus_rdata[15])
            |-> (bus_rdata[14:0] == 15'd0));

    // R8
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != OFF_STATUS && bus_addr != OFF_THRESH &&
         bus_addr != OFF_HOST && bus_addr != OFF_FPGA) |-> (bus_rdata == '0));

endmodule

bind pwr_guard_regs pwr_guard_regs_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rdata    (bus_rdata),
    .pwr_vld      (pwr_vld),
    .cons_q       (cons_q),
    .th_a         (th_q[0]),
    .alarm_lo     (alarm_lo),
    .alarm_hi     (alarm_hi),
    .throttle_lvl (throttle_lvl)
);

// File: tb/tb_pwr_guard_regs.sv
`timescale 1ns/1ps
module tb_pwr_guard_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic [17:0] pwr_in = '0;
    logic        pwr_vld = 1'b0;
    logic        lat_ok_in = 1'b0;
    logic [14:0] host_lim_in = '0;
    logic        host_lim_en = 1'b0;
    logic [14:0] fpga_lim_in = '0;
    logic        fpga_lim_en = 1'b0;
    logic        alarm_lo, alarm_hi;
    logic [1:0]  throttle_lvl;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // Bench model
    logic [17:0] m_cons;
    logic [6:0]  m_tha, m_thb;
    logic        m_lat;
    logic [14:0] m_hv, m_fv;
    logic        m_he, m_fe;

    always #4 clk = ~clk;

    pwr_guard_regs dut (.*);

    function automatic logic [1:0] f_lvl(logic [17:0] c, logic [6:0] a, logic [6:0] b);
        if (c >= {11'd0, b}) return 2'd2;
        if (c >= {11'd0, a}) return 2'd1;
        return 2'd0;
    endfunction

    function automatic logic [63:0] f_thr_word(logic [17:0] c, logic [6:0] a, logic [6:0] b);
        logic [63:0] w = '0;
        w[6:0]  = a;
        w[14:8] = b;
        w[16]   = (c >= {11'd0, a});
        w[17]   = (c >= {11'd0, b});
        return w;
    endfunction

    function automatic logic [63:0] f_lim(logic en, logic [14:0] v);
        return {48'd0, en, (en ? v : 15'd0)};
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(logic [7:0] a, output logic [63:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(logic [7:0] a, logic [63:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        if (a == 8'h10) begin m_tha = d[6:0]; m_thb = d[14:8]; end
    endtask

    task automatic smp(logic [17:0] p);
        pwr_in = p; pwr_vld = 1'b1;
        @(posedge clk); #1;
        pwr_vld = 1'b0;
        m_cons = p;
    endtask

    task automatic settle();
        @(posedge clk); #1;
    endtask

    task automatic check_all(string tag);
        logic [63:0] d;
        chk({"R5 lvl ", tag}, 64'(throttle_lvl), 64'(f_lvl(m_cons, m_tha, m_thb)));
        chk({"R4 alarm_lo ", tag}, 64'(alarm_lo), 64'(m_cons >= {11'd0, m_tha}));
        chk({"R4 alarm_hi ", tag}, 64'(alarm_hi), 64'(m_cons >= {11'd0, m_thb}));
        rd(8'h08, d); chk({"R2 status ", tag}, d, {45'd0, m_lat, m_cons});
        rd(8'h10, d); chk({"R3 thresh ", tag}, d, f_thr_word(m_cons, m_tha, m_thb));
        rd(8'h18, d); chk({"R6 host ", tag}, d, f_lim(m_he, m_hv));
        rd(8'h20, d); chk({"R6 fpga ", tag}, d, f_lim(m_fe, m_fv));
    endtask

    initial begin
        logic [63:0] d;
        logic [1:0]  lvl_before;
        void'($urandom(32'd20240611));
        m_cons = '0; m_tha = 7'h7F; m_thb = 7'h7F; m_lat = 0;
        m_hv = '0; m_fv = '0; m_he = 0; m_fe = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        check_all("r1_reset");

        // R3 junk in unused bits ignored
        wr(8'h10, 64'hFFFF_FFFF_FFFF_8380 | 64'h0000_0000_0000_0A05);
        settle();
        check_all("r3_junk");

        // R5 level must not move in the clock where the sample lands
        wr(8'h10, {48'd0, 8'd40, 8'd20}); settle();
        lvl_before = throttle_lvl;
        smp(18'd30);
        chk("R5 level holds one clock", 64'(throttle_lvl), 64'(lvl_before));
        settle();
        chk("R5 level after one clock", 64'(throttle_lvl), 64'd1);

        // R4 exact equality with threshold B
        smp(18'd40); settle();
        check_all("r4_equal");

        // R5 inverted pair: B below A, consumption between
        wr(8'h10, {48'd0, 8'd10, 8'd50}); smp(18'd20); settle();
        check_all("r5_inverted");

        // R4 zero thresholds always reached
        wr(8'h10, 64'd0); smp(18'd0); settle();
        check_all("r4_zero");

        // R4 full-scale sample against max thresholds
        wr(8'h10, {48'd0, 8'h7F, 8'h7F}); smp(18'h3FFFF); settle();
        check_all("r4_fullscale");

        // R7 writes to read-only offsets ignored
        wr(8'h08, '1); wr(8'h18, '1); wr(8'h20, '1); wr(8'h30, '1); settle();
        check_all("r7_ro");
        // R8 unmapped read
        rd(8'h28, d); chk("R8 unmapped read", d, 64'd0);

        // R6 limits enabled and disabled
        host_lim_in = 15'h1234; host_lim_en = 1; fpga_lim_in = 15'h7FFF; fpga_lim_en = 0;
        m_hv = 15'h1234; m_he = 1; m_fv = 15'h7FFF; m_fe = 0;
        lat_ok_in = 1; m_lat = 1;
        settle();
        check_all("r6_limits");

        // R9 no sample strobe: input changes ignored
        pwr_in = 18'd5; settle(); settle();
        check_all("r9_hold");

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom % 6;
            case (op)
                0: wr(8'h10, {$urandom, 16'($urandom), 1'b0, 7'($urandom % 48), 1'b0, 7'($urandom % 48)});
                1: smp(($urandom % 8 == 0) ? 18'($urandom) : 18'($urandom % 56));
                2: begin lat_ok_in = 1'($urandom); m_lat = lat_ok_in; settle(); end
                3: begin
                    host_lim_in = 15'($urandom); host_lim_en = 1'($urandom);
                    fpga_lim_in = 15'($urandom); fpga_lim_en = 1'($urandom);
                    m_hv = host_lim_in; m_he = host_lim_en; m_fv = fpga_lim_in; m_fe = fpga_lim_en;
                    settle();
                end
                4: wr(8'($urandom % 5) << 3 == 8'h10 ? 8'h08 : 8'($urandom % 5) << 3, {$urandom, $urandom});
                default: begin pwr_in = 18'($urandom); settle(); end
            endcase
            settle();
            check_all("random");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        #(8 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule